// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a 32-bit load-store RISC core and decides, every clock, where the next fetch goes. It decodes the instruction word currently being executed and chooses among four kinds of next address. The first is the fall-through address PC+4. The second is a PC-relative branch target, used when the branch condition holds. The third is an absolute target inside the current 256 MB region. The fourth is a register-supplied address.

The equality compare of the two source registers, the floating-point condition flag and the value of the source register are computed elsewhere in the core and arrive as inputs. The unit also presents PC+4 and the call return address PC+8 to the rest of the core. A stall input freezes the counter. A synchronous reset loads a parameterised reset vector.

Top module: `npc_unit`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, `pc_o` becomes `RESET_VEC` after that edge, whatever the other inputs are, including `stall_i`.
- R2: When `stall_i` is high and `rst_i` is low at an edge, `pc_o` keeps its value, whatever instruction is presented.
- R3: An instruction whose opcode (bits 31:26) is not one of 0x00, 0x02, 0x03, 0x04, 0x05 or 0x11 advances `pc_o` to PC+4.
- R4: Opcode 0x04 (equal-branch) with `regs_equal_i`=1 loads PC+4 plus the offset. The offset is bits 15:0 sign-extended and multiplied by four. With `regs_equal_i`=0, the instruction loads PC+4.
- R5: Opcode 0x05 (not-equal-branch) loads the same branch target when `regs_equal_i`=0 and loads PC+4 when `regs_equal_i`=1.
- R6: Opcode 0x02 loads an absolute target built from three parts: bits 31:28 of PC+4, then instruction bits 25:0, then two zero bits.
- R7: Opcode 0x03 (call) loads the same absolute target as R6. `link_o` always equals PC+8, so the core writes the return address to register 31.
- R8: Opcode 0x00 with function field (bits 5:0) equal to 0x08 loads `rs_value_i`. Opcode 0x00 with any other function field loads PC+4.
- R9: Opcode 0x11 with bits 25:21 equal to 8 is a flag branch. It loads the branch target when bit 16 equals `fp_cond_i`, and PC+4 otherwise. Opcode 0x11 with any other value in bits 25:21 loads PC+4.
- R10: `pc_plus4_o` equals `pc_o`+4 at all times.
- R11: All address arithmetic wraps modulo 2^32. A negative offset moves the PC backward, and PC+4 from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hold the PC this cycle |
| instr_i | input | 32 | Instruction word at the current PC |
| regs_equal_i | input | 1 | The two source registers compare equal |
| fp_cond_i | input | 1 | Floating-point condition flag |
| rs_value_i | input | 32 | Source register value for indirect jumps |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Sequential address PC+4 |
| link_o | output | 32 | Return address PC+8 |

## Verification
The bench builds the unit with `RESET_VEC` = 0xEFFFFFFC, the last word of a region. The very first absolute jump therefore takes its upper bits from PC+4 (0xF) rather than from PC (0xE), so a splice taken from the wrong address shows up. An indirect jump to 0xFFFFFFF8 followed by two sequential steps reaches the 32-bit wrap to zero. A backward not-equal branch exercises the negative sign extension.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN   = 32;
    localparam int OP_W   = 6;
    localparam int FMT_W  = 5;
    localparam int FN_W   = 6;
    localparam int IMM_W  = 16;
    localparam int IDX_W  = 26;

    localparam logic [OP_W-1:0]  OPC_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0]  OPC_JUMP    = 6'h02;
    localparam logic [OP_W-1:0]  OPC_CALL    = 6'h03;
    localparam logic [OP_W-1:0]  OPC_BR_EQ   = 6'h04;
    localparam logic [OP_W-1:0]  OPC_BR_NE   = 6'h05;
    localparam logic [OP_W-1:0]  OPC_FPU     = 6'h11;
    localparam logic [FN_W-1:0]  FN_JREG     = 6'h08;
    localparam logic [FMT_W-1:0] FMT_FLAGBR  = 5'h08;

    typedef enum logic [1:0] {
        NPC_SEQ = 2'd0,
        NPC_REL = 2'd1,
        NPC_ABS = 2'd2,
        NPC_IND = 2'd3
    } npc_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } npc_state_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0]  opcode_i,
    input  logic [FMT_W-1:0] fmt_i,
    input  logic [FN_W-1:0]  funct_i,
    input  logic             tf_bit_i,
    input  logic             regs_equal_i,
    input  logic             fp_cond_i,
    output npc_sel_e         sel_o
);

    logic flag_hit;

    always_comb begin
        flag_hit = (fmt_i == FMT_FLAGBR) && (tf_bit_i == fp_cond_i);
        sel_o    = NPC_SEQ;
        unique case (opcode_i)
            OPC_JUMP,
            OPC_CALL:    sel_o = NPC_ABS;
            OPC_BR_EQ:   sel_o = regs_equal_i  ? NPC_REL : NPC_SEQ;
            OPC_BR_NE:   sel_o = !regs_equal_i ? NPC_REL : NPC_SEQ;
            OPC_SPECIAL: sel_o = (funct_i == FN_JREG) ? NPC_IND : NPC_SEQ;
            OPC_FPU:     sel_o = flag_hit ? NPC_REL : NPC_SEQ;
            default:     sel_o = NPC_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]     pc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [W-1:0]     rs_value_i,
    input  npc_sel_e         sel_i,
    output logic [W-1:0]     pc_plus4_o,
    output logic [W-1:0]     pc_plus8_o,
    output logic [W-1:0]     target_o
);

    localparam int EXT_W  = W - IMM_W - 2;
    localparam int KEEP_W = W - IDX_W - 2;

    logic [W-1:0] rel_ofs;
    logic [W-1:0] rel_tgt;
    logic [W-1:0] abs_tgt;

    always_comb begin
        pc_plus4_o = pc_i + W'(4);
        pc_plus8_o = pc_i + W'(8);
        rel_ofs    = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
        rel_tgt    = pc_plus4_o + rel_ofs;
        abs_tgt    = {pc_plus4_o[W-1 -: KEEP_W], idx_i, 2'b00};
        unique case (sel_i)
            NPC_REL: target_o = rel_tgt;
            NPC_ABS: target_o = abs_tgt;
            NPC_IND: target_o = rs_value_i;
            default: target_o = pc_plus4_o;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            stall_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic            regs_equal_i,
    input  logic            fp_cond_i,
    input  logic [XLEN-1:0] rs_value_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] pc_plus4_o,
    output logic [XLEN-1:0] link_o
);

    localparam int OP_LO  = XLEN - OP_W;
    localparam int FMT_LO = OP_LO - FMT_W;
    localparam int TF_POS = 16;

    npc_state_t      st_d, st_q;
    npc_sel_e        sel;
    logic [XLEN-1:0] target;

    npc_decode u_decode (
        .opcode_i     (instr_i[XLEN-1:OP_LO]),
        .fmt_i        (instr_i[OP_LO-1:FMT_LO]),
        .funct_i      (instr_i[FN_W-1:0]),
        .tf_bit_i     (instr_i[TF_POS]),
        .regs_equal_i (regs_equal_i),
        .fp_cond_i    (fp_cond_i),
        .sel_o        (sel)
    );

    npc_target #(.W(XLEN)) u_target (
        .pc_i       (st_q.pc),
        .imm_i      (instr_i[IMM_W-1:0]),
        .idx_i      (instr_i[IDX_W-1:0]),
        .rs_value_i (rs_value_i),
        .sel_i      (sel),
        .pc_plus4_o (pc_plus4_o),
        .pc_plus8_o (link_o),
        .target_o   (target)
    );

    always_comb begin
        st_d = st_q;
        if (!stall_i) begin
            st_d.pc = target;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.pc <= RESET_VEC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

    AST_RESET_LOADS: assert property (@(posedge clk_i) rst_i |=> pc_o == RESET_VEC); // R1
    AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_i |=> pc_o == $past(pc_o)); // R2
    AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && sel == NPC_SEQ) |=> pc_o == $past(pc_o) + 32'd4); // R3
    AST_BEQ_FALLS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && instr_i[XLEN-1:OP_LO] == OPC_BR_EQ && !regs_equal_i)
        |=> pc_o == $past(pc_o) + 32'd4); // R4
    AST_BNE_FALLS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && instr_i[XLEN-1:OP_LO] == OPC_BR_NE && regs_equal_i)
        |=> pc_o == $past(pc_o) + 32'd4); // R5
    AST_ABS_REGION: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && sel == NPC_ABS)
        |=> (pc_o[XLEN-1 -: 4] == $past(pc_plus4_o[XLEN-1 -: 4])) && (pc_o[1:0] == 2'b00)); // R6
    AST_LINK_AHEAD: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |-> link_o - pc_o == 32'd8); // R7
    AST_IND_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && sel == NPC_IND) |=> pc_o == $past(rs_value_i)); // R8

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;

    localparam logic [31:0] RV = 32'hEFFF_FFFC;

    typedef struct {
        logic [31:0] pc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [31:0] instr = 32'h0000_0021;
    logic        req = 1'b0;
    logic        fpc = 1'b0;
    logic [31:0] rsv = 32'h0;
    logic [31:0] pc_o, pc4_o, link_o;

    int    n_chk = 0;
    int    n_bad = 0;
    logic  [31:0] model_pc = RV;
    exp_t  sb_q[$];
    bit    done = 1'b0;

    always #5 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) dut_i (
        .clk_i(clk), .rst_i(rst), .stall_i(stall), .instr_i(instr),
        .regs_equal_i(req), .fp_cond_i(fpc), .rs_value_i(rsv),
        .pc_o(pc_o), .pc_plus4_o(pc4_o), .link_o(link_o)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] f1,
                                          input logic [4:0] f2, input logic [15:0] imm);
        return {op, f1, f2, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction

    function automatic logic [31:0] expect_next(input logic [31:0] pc, input logic [31:0] ins,
                                                input logic eq, input logic fp,
                                                input logic [31:0] rv, input logic stl);
        logic [31:0] seq, br;
        seq = pc + 32'd4;
        br  = seq + {{14{ins[15]}}, ins[15:0], 2'b00};
        if (stl) return pc;
        case (ins[31:26])
            6'h02, 6'h03: return {seq[31:28], ins[25:0], 2'b00};
            6'h04: return eq ? br : seq;
            6'h05: return eq ? seq : br;
            6'h00: return (ins[5:0] == 6'h08) ? rv : seq;
            6'h11: return (ins[25:21] == 5'd8 && ins[16] == fp) ? br : seq;
            default: return seq;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic stl, input string tag);
        exp_t it;
        @(negedge clk);
        rst = 1'b1; stall = stl; instr = enc_j(6'h02, 26'h3FF_FFFF);
        it.pc = RV; it.tag = tag;
        sb_q.push_back(it);
        model_pc = RV;
    endtask

    task automatic step(input logic [31:0] ins, input logic eq, input logic fp,
                        input logic [31:0] rv, input logic stl, input string tag);
        exp_t it;
        @(negedge clk);
        rst = 1'b0; instr = ins; req = eq; fpc = fp; rsv = rv; stall = stl;
        #1;
        check("R10 pc_plus4", pc4_o, model_pc + 32'd4);
        check("R7 link", link_o, model_pc + 32'd8);
        it.pc  = expect_next(model_pc, ins, eq, fp, rv, stl);
        it.tag = tag;
        sb_q.push_back(it);
        model_pc = it.pc;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check(it.tag, pc_o, it.pc);
            end
        end
    end

    initial begin : driver
        do_reset(1'b0, "R1 reset vector");
        step(enc_j(6'h02, 26'h000_0010), 0, 0, 0, 0, "R6 jump takes region of PC+4");
        step(32'h0000_0021, 0, 0, 0, 0, "R8 other funct is sequential");
        step(enc_i(6'h04, 5'd1, 5'd2, 16'h0010), 1, 0, 0, 0, "R4 beq taken");
        step(enc_i(6'h04, 5'd1, 5'd2, 16'h0010), 0, 0, 0, 0, "R4 beq not taken");
        step(enc_i(6'h05, 5'd1, 5'd2, 16'hFFFE), 0, 0, 0, 0, "R5 R11 bne taken backward");
        step(enc_i(6'h05, 5'd1, 5'd2, 16'h0100), 1, 0, 0, 0, "R5 bne not taken");
        step(enc_j(6'h03, 26'h123_4567), 0, 0, 0, 1, "R2 stall holds over call");
        step(enc_i(6'h00, 5'd3, 5'd0, 16'h0008), 0, 0, 32'h1234_5678, 1, "R2 stall holds over jr");
        step(enc_j(6'h03, 26'h123_4567), 0, 0, 0, 0, "R7 call target");
        step(enc_i(6'h00, 5'd3, 5'd0, 16'h0008), 0, 0, 32'hFFFF_FFF8, 0, "R8 register jump");
        step(32'h8C00_0000, 0, 0, 0, 0, "R3 load word is sequential");
        step(32'h0000_0021, 0, 0, 0, 0, "R11 sequential wraps to zero");
        step(enc_i(6'h11, 5'd8, 5'd1, 16'h0020), 0, 1, 0, 0, "R9 flag-true branch taken");
        step(enc_i(6'h11, 5'd8, 5'd1, 16'h0020), 0, 0, 0, 0, "R9 flag-true branch not taken");
        step(enc_i(6'h11, 5'd8, 5'd0, 16'h0040), 0, 0, 0, 0, "R9 flag-false branch taken");
        step(enc_i(6'h11, 5'd8, 5'd0, 16'h0040), 0, 1, 0, 0, "R9 flag-false branch not taken");
        step(enc_i(6'h11, 5'd16, 5'd1, 16'h0040), 0, 1, 0, 0, "R9 other fmt is sequential");
        step(enc_i(6'h08, 5'd1, 5'd2, 16'hFFFF), 1, 1, 32'h0, 0, "R3 immediate add is sequential");
        do_reset(1'b1, "R1 reset overrides stall");
        step(enc_i(6'h04, 5'd1, 5'd2, 16'h8000), 1, 0, 0, 0, "R4 R11 most negative offset");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule